// File: doc/BRIEF.md
# Variable-Length Operand Address Unit

This block works out where the operand of a one-word or two-word instruction lives. When `start` is pulsed it samples the first instruction word, the optional second word, the program counter and two index registers (a link register and an index register). It decides whether the instruction has a short or a long address form and reports this on `len_two`, so that the fetch logic can advance the program counter by one or two words. It then forms a 15-bit effective address.

In the long form the second word may request indirection. The unit then follows a chain of pointer words through a one-cycle-latency memory read port. The chain ends at the first pointer word whose top bit is clear. Every address the unit forms, including each pointer it would fetch through, is compared against the installed memory size. An address beyond it stops the walk with a non-existent-memory trap.

The unit computes the address only. It does not execute the operation and it does not fetch the instruction.

Top module: `eau_top`

## Requirements
- R1: After synchronous reset, `done`, `mem_rd`, `len_two` and `nxm_trap` are 0 and `ea` is 0.
- R2: Field positions: the operation code is `iword0[15:13]`, the mode field is `iword0[9:8]` and the displacement is `iword0[7:0]`. The long form applies when the operation code is greater than 5 or the displacement equals 8'h80. `len_two` is 1 for the long form and 0 for the short form.
- R3: Short form, all arithmetic modulo 2^15:
  - mode 0 gives the zero-extended displacement;
  - mode 1 gives `pc` plus the sign-extended displacement;
  - mode 2 gives `link_reg[14:0]` plus the sign-extended displacement;
  - mode 3 gives `idx_reg[14:0]` plus the sign-extended displacement.
- R4: Long form: `iword1[15]` is the indirect flag and `iword1[14:0]` is the address. Mode 0 gives that address, mode 2 gives `link_reg[14:0]` plus it and mode 3 gives `idx_reg[14:0]` plus it, modulo 2^15.
- R5: Long form with mode 1 is immediate. `ea` is `pc+1` modulo 2^15, `iword1[15]` is ignored and no memory read is made.
- R6: When the indirect flag is set, the unit reads the word at the computed address. `mem_rdata` is taken in the cycle after `mem_rd`. Bit 15 of the word read requests a further level and bits 14:0 give the next address. Chains of any depth are followed, and the final address is the one from the word whose bit 15 is clear.
- R7: `done` is a one-cycle pulse. It is high in the first cycle after the `start` edge when there is no indirection, and two cycles later for each indirect read.
- R8: Any address that is not below `MEM_WORDS`, whether initial or read from a pointer, ends the operation with `nxm_trap`=1 and `ea` equal to that address. That address is never placed on the read port.
- R9: `start` is ignored while an operation is in progress. The result of the running operation is unchanged and no extra `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (accepted when idle) |
| iword0 | input | 16 | First instruction word |
| iword1 | input | 16 | Second instruction word (used in long form) |
| pc | input | 15 | Address of the first instruction word |
| link_reg | input | 16 | Link register |
| idx_reg | input | 16 | Index register |
| mem_rd | output | 1 | Pointer read request |
| mem_addr | output | 15 | Pointer read address |
| mem_rdata | input | 16 | Pointer word, valid the cycle after `mem_rd` |
| done | output | 1 | Result valid pulse |
| ea | output | 15 | Effective address (or faulting address on trap) |
| len_two | output | 1 | Instruction is two words long |
| nxm_trap | output | 1 | Address beyond installed memory |

## Verification
The assertions watch, on every cycle, several properties of the walk:
- `done` never lasts more than one cycle;
- every read request lies inside installed memory and is followed by a cycle without a request;
- a trap-free result is in range;
- the length flag holds steady while a chain is walked.

Only the bench scenarios can show the arithmetic itself: the short and long mode table, sign extension, 15-bit wrap, immediate mode, multi-level chains, the exact latency per level, and the rejection of a `start` raised mid-walk.

// File: rtl/eau_pkg.sv
package eau_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned ADDR_W = 15;
    localparam int unsigned DISP_W = 8;
    localparam logic [DISP_W-1:0] LONG_ESCAPE = 8'h80;
    localparam logic [2:0] SHORT_OPC_MAX = 3'd5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        XM_ABS   = 2'd0,
        XM_PCREL = 2'd1,
        XM_LINK  = 2'd2,
        XM_INDEX = 2'd3
    } xmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_FIN
    } walk_e;

    // First instruction word; the MSB is field position 0.
    typedef struct packed {
        logic [2:0]        opc;
        logic [2:0]        rsel;
        xmode_e            xm;
        logic [DISP_W-1:0] disp;
    } iw0_t;

    // Second word of the long form.
    typedef struct packed {
        logic  indir;
        addr_t addr;
    } iw1_t;

    // Result of decoding, handed to the chain walker.
    typedef struct packed {
        addr_t addr;
        logic  indir;
        logic  two_words;
    } eastart_t;

    function automatic logic is_long(iw0_t w);
        return (w.opc > SHORT_OPC_MAX) || (w.disp == LONG_ESCAPE);
    endfunction

    function automatic addr_t sext_disp(logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic addr_t zext_disp(logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){1'b0}}, d};
    endfunction

endpackage

// File: rtl/eau_decode.sv
module eau_decode
    import eau_pkg::*;
(
    input  word_t    iword0,
    input  word_t    iword1,
    input  addr_t    pc,
    input  word_t    link_reg,
    input  word_t    idx_reg,
    output eastart_t first
);
    iw0_t  w0;
    iw1_t  w1;
    logic  long_form;
    addr_t base;
    addr_t offset;
    logic  unused_bits;

    assign w0 = iw0_t'(iword0);
    assign w1 = iw1_t'(iword1);
    assign long_form = is_long(w0);
    assign unused_bits = ^{w0.rsel, link_reg[WORD_W-1], idx_reg[WORD_W-1]};

    always_comb begin
        unique case (w0.xm)
            XM_ABS:   base = '0;
            XM_PCREL: base = pc;
            XM_LINK:  base = link_reg[ADDR_W-1:0];
            default:  base = idx_reg[ADDR_W-1:0];
        endcase
    end

    always_comb begin
        if (long_form)
            offset = w1.addr;
        else if (w0.xm == XM_ABS)
            offset = zext_disp(w0.disp);
        else
            offset = sext_disp(w0.disp);
    end

    always_comb begin
        first.two_words = long_form;
        if (long_form && (w0.xm == XM_PCREL)) begin
            // Immediate: the operand is the word after the instruction.
            first.addr  = pc + addr_t'(1);
            first.indir = 1'b0;
        end else begin
            first.addr  = base + offset;
            first.indir = long_form & w1.indir;
        end
    end

endmodule

// File: rtl/eau_bound.sv
module eau_bound
    import eau_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 32768
) (
    input  addr_t addr,
    output logic  nxm
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_WORDS);

    assign nxm = ({1'b0, addr} >= LIMIT);

endmodule

// File: rtl/eau_walker.sv
module eau_walker
    import eau_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 32768
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  eastart_t first,
    input  logic     first_nxm,
    input  word_t    mem_rdata,
    input  logic     hop_nxm,
    output logic     mem_rd,
    output addr_t    mem_addr,
    output logic     done,
    output addr_t    ea,
    output logic     len_two,
    output logic     nxm_trap
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_WORDS);

    walk_e state;
    addr_t ptr;
    addr_t ea_q;
    logic  len_q;
    logic  trap_q;
    iw1_t  hop;

    assign hop = iw1_t'(mem_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            ea_q   <= '0;
            len_q  <= 1'b0;
            trap_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    len_q <= first.two_words;
                    if (first_nxm) begin
                        ea_q   <= first.addr;
                        trap_q <= 1'b1;
                        state  <= ST_FIN;
                    end else if (first.indir) begin
                        ptr    <= first.addr;
                        trap_q <= 1'b0;
                        state  <= ST_FETCH;
                    end else begin
                        ea_q   <= first.addr;
                        trap_q <= 1'b0;
                        state  <= ST_FIN;
                    end
                end
                ST_FETCH: state <= ST_WAIT;
                ST_WAIT: begin
                    if (hop_nxm) begin
                        ea_q   <= hop.addr;
                        trap_q <= 1'b1;
                        state  <= ST_FIN;
                    end else if (hop.indir) begin
                        ptr   <= hop.addr;
                        state <= ST_FETCH;
                    end else begin
                        ea_q  <= hop.addr;
                        state <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd   = (state == ST_FETCH);
    assign mem_addr = ptr;
    assign done     = (state == ST_FIN);
    assign ea       = ea_q;
    assign len_two  = len_q;
    assign nxm_trap = trap_q;

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_read_in_range: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> ({1'b0, mem_addr} < LIMIT));

    a_r8_result_in_range: assert property (@(posedge clk) disable iff (rst)
        (done && !nxm_trap) |-> ({1'b0, ea} < LIMIT));

    a_r6_read_gap: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (!mem_rd && !done));

    a_r9_len_held: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH || state == ST_WAIT) |=> $stable(len_two));

endmodule

// File: rtl/eau_top.sv
module eau_top
    import eau_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 32768
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] iword0,
    input  logic [15:0] iword1,
    input  logic [14:0] pc,
    input  logic [15:0] link_reg,
    input  logic [15:0] idx_reg,
    output logic        mem_rd,
    output logic [14:0] mem_addr,
    input  logic [15:0] mem_rdata,
    output logic        done,
    output logic [14:0] ea,
    output logic        len_two,
    output logic        nxm_trap
);
    eastart_t first;
    logic     first_nxm;
    logic     hop_nxm;

    eau_decode u_decode (
        .iword0   (iword0),
        .iword1   (iword1),
        .pc       (pc),
        .link_reg (link_reg),
        .idx_reg  (idx_reg),
        .first    (first)
    );

    eau_bound #(.MEM_WORDS(MEM_WORDS)) u_bound_first (
        .addr (first.addr),
        .nxm  (first_nxm)
    );

    eau_bound #(.MEM_WORDS(MEM_WORDS)) u_bound_hop (
        .addr (mem_rdata[ADDR_W-1:0]),
        .nxm  (hop_nxm)
    );

    eau_walker #(.MEM_WORDS(MEM_WORDS)) u_walker (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .first     (first),
        .first_nxm (first_nxm),
        .mem_rdata (mem_rdata),
        .hop_nxm   (hop_nxm),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .done      (done),
        .ea        (ea),
        .len_two   (len_two),
        .nxm_trap  (nxm_trap)
    );

endmodule

// File: tb/sim_eau_top.sv
`timescale 1ns/1ps
module sim_eau_top;

    localparam int unsigned MEMW = 4096;
    localparam int NV = 17;

    typedef struct packed {
        logic [15:0] w0;
        logic [15:0] w1;
        logic [14:0] pc;
        logic [15:0] lk;
        logic [15:0] ix;
        logic [14:0] ea;
        logic        ln;
        logic        tr;
        logic [3:0]  rd;
    } vec_t;

    // Fields: w0, w1, pc, link, index, exp ea, exp len, exp trap, exp reads
    localparam vec_t VECS [NV] = '{
        '{16'h0045, 16'h0000, 15'h0100, 16'h0200, 16'h0FF0, 15'h0045, 1'b0, 1'b0, 4'd0}, // R3 x0
        '{16'h41F0, 16'h0000, 15'h0100, 16'h0200, 16'h0FF0, 15'h00F0, 1'b0, 1'b0, 4'd0}, // R3 x1 neg
        '{16'h627F, 16'h0000, 15'h0100, 16'h0200, 16'h0FF0, 15'h027F, 1'b0, 1'b0, 4'd0}, // R3 x2
        '{16'hA310, 16'h0000, 15'h0100, 16'h0200, 16'h7FF8, 15'h0008, 1'b0, 1'b0, 4'd0}, // R3 wrap
        '{16'hA3FF, 16'h0000, 15'h0100, 16'h0200, 16'h8010, 15'h000F, 1'b0, 1'b0, 4'd0}, // R3 idx bit15
        '{16'h0080, 16'h0ABC, 15'h0100, 16'h0200, 16'h0FF0, 15'h0ABC, 1'b1, 1'b0, 4'd0}, // R2 R4 escape
        '{16'hC212, 16'h0100, 15'h0100, 16'h0200, 16'h0FF0, 15'h0300, 1'b1, 1'b0, 4'd0}, // R4 link
        '{16'hE305, 16'h0010, 15'h0100, 16'h0200, 16'h0FF0, 15'h1000, 1'b1, 1'b1, 4'd0}, // R8 edge
        '{16'hC133, 16'h8FFF, 15'h7FFF, 16'h0200, 16'h0FF0, 15'h0000, 1'b1, 1'b0, 4'd0}, // R5 imm
        '{16'h2080, 16'h8500, 15'h0100, 16'h0200, 16'h0FF0, 15'h0222, 1'b1, 1'b0, 4'd1}, // R6 one
        '{16'h2080, 16'h8300, 15'h0100, 16'h0200, 16'h0FF0, 15'h0123, 1'b1, 1'b0, 4'd2}, // R6 two
        '{16'h8280, 16'h8500, 15'h0100, 16'h0200, 16'h0FF0, 15'h0123, 1'b1, 1'b0, 4'd3}, // R6 three
        '{16'h2080, 16'h8600, 15'h0100, 16'h0200, 16'h0FF0, 15'h2000, 1'b1, 1'b1, 4'd1}, // R8 hop
        '{16'h80FF, 16'h0000, 15'h0100, 16'h0200, 16'h0FF0, 15'h00FF, 1'b0, 1'b0, 4'd0}, // R2 short
        '{16'hA080, 16'h0FFF, 15'h0100, 16'h0200, 16'h0FF0, 15'h0FFF, 1'b1, 1'b0, 4'd0}, // R2 op5 esc
        '{16'h0080, 16'h9000, 15'h0100, 16'h0200, 16'h0FF0, 15'h1000, 1'b1, 1'b1, 4'd0}, // R8 no read
        '{16'h627F, 16'h0000, 15'h0100, 16'h0FC0, 16'h0FF0, 15'h103F, 1'b0, 1'b1, 4'd0}  // R8 short
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] iword0 = '0;
    logic [15:0] iword1 = '0;
    logic [14:0] pc = '0;
    logic [15:0] link_reg = '0;
    logic [15:0] idx_reg = '0;
    logic        mem_rd;
    logic [14:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic [14:0] ea;
    logic        len_two;
    logic        nxm_trap;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    eau_top #(.MEM_WORDS(MEMW)) u0 (
        .clk(clk), .rst(rst), .start(start), .iword0(iword0), .iword1(iword1),
        .pc(pc), .link_reg(link_reg), .idx_reg(idx_reg), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .ea(ea),
        .len_two(len_two), .nxm_trap(nxm_trap)
    );

    function automatic logic [15:0] mem_at(logic [14:0] a);
        case (a)
            15'h0300: return 16'h8400;
            15'h0400: return 16'h0123;
            15'h0500: return 16'h0222;
            15'h0600: return 16'h2000;
            15'h0700: return 16'h8300;
            default:  return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mem_at(mem_addr);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Runs one operation; returns cycles to done and reads seen.
    task automatic run_op(vec_t v, output int cyc, output int rds, input bit poke_busy);
        @(negedge clk);
        iword0 = v.w0; iword1 = v.w1; pc = v.pc; link_reg = v.lk; idx_reg = v.ix;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        rds = 0;
        while (!done && cyc < 60) begin
            if (mem_rd) rds++;
            if (poke_busy && cyc == 2) begin
                iword0 = 16'h0045; iword1 = 16'h0000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
    endtask

    initial begin
        int cyc;
        int rds;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 done", done, 0);
        check("R1 mem_rd", mem_rd, 0);
        check("R1 ea", ea, 0);
        check("R1 len_two", len_two, 0);
        check("R1 nxm_trap", nxm_trap, 0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i], cyc, rds, 1'b0);
            check("R3/R4/R5 ea", ea, VECS[i].ea);
            check("R2 len_two", len_two, VECS[i].ln);
            check("R8 nxm_trap", nxm_trap, VECS[i].tr);
            check("R6 reads", rds, VECS[i].rd);
            check("R7 latency", cyc, 1 + 2 * VECS[i].rd);
            @(negedge clk);
            check("R7 done pulse", done, 0);
        end

        // R9: start raised mid-walk must not disturb the three-level chain.
        run_op(VECS[11], cyc, rds, 1'b1);
        check("R9 ea", ea, 15'h0123);
        check("R9 latency", cyc, 7);
        check("R9 reads", rds, 3);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9 no extra done", done, 0);
        end

        // R1: reset mid-operation returns to the reset state
        @(negedge clk);
        iword0 = 16'h2080; iword1 = 16'h8300; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset mem_rd", mem_rd, 0);
        check("R1 mid reset len_two", len_two, 0);
        check("R1 mid reset ea", ea, 0);

        finished = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule